// File: doc/BRIEF.md
# Serial Slave Mode Controller

This block is the top-level mode sequencer for a memory slave that talks over one bidirectional wire. It follows the device through four modes (shutdown, idle, standby and active) and, while active, judges every byte and acknowledge that the bit receiver hands it. From these it decides whether a command carries on, ends cleanly, or is abandoned. Bit timing, Manchester decoding and the storage array lie outside it: it sees the sampled line level, one-cycle byte and acknowledge events, a missed-edge flag, a busy flag from the array and a write-permission flag from the protection logic.

A command begins after a standby pulse (the line held high for `STBY_CYC` clock samples) and a falling edge. The first byte is the device address, the second the command code, and any further bytes are parameters or data. After each byte the master sends either an acknowledge (MAK) or a no-acknowledge (NoMAK). A NoMAK ends the command normally and returns the device to standby. For the four commands that change stored content, a NoMAK at the right point also fires a one-cycle write-start pulse. Any protocol fault sends the device to idle. In idle all traffic is ignored until the next standby pulse.

Top module: `smc_mode_ctrl`

## Requirements
- R1: During and right after reset, `mode_o` is shutdown (encoding: 0 shutdown, 1 idle, 2 standby, 3 active), and `cmd_valid_o` and `wr_start_o` are 0.
- R2: In shutdown, a low-to-high change of `line_i` moves the mode to idle at that clock edge. No other input leaves shutdown.
- R3: When `line_i` is sampled high on `STBY_CYC` consecutive clock edges, the mode becomes standby at the last of them, from idle, standby or active. This standby pulse wins over every other event in the same cycle. A shorter high period changes nothing.
- R4: In idle, bytes, acknowledges, missed edges and line falls have no effect: the mode stays idle and `cmd_valid_o` stays 0.
- R5: In standby, a high-to-low change of `line_i` makes the mode active, expecting an address byte, with `cmd_valid_o` still 0.
- R6: An address byte equal to `DEV_ADDR` is accepted. Any other address value gives idle. After an accepted address, a MAK moves on to the command byte and a NoMAK gives standby.
- R7: Command codes are: read 0x03, read-current 0x06, write 0x6C, write-enable 0x96, write-disable 0x91, read-status 0x05, write-status 0x6E, clear-all 0x6D, fill-all 0x67. A known code sets `cmd_valid_o` to 1 and keeps the mode active. Any other code gives idle.
- R8: While `wip_i` is 1, read, read-current, write, write-status, fill-all and clear-all are rejected and give idle. Write-enable, write-disable and read-status are still accepted.
- R9: After the command byte of write-enable, write-disable, fill-all or clear-all, a MAK gives idle and a NoMAK gives standby.
- R10: For write-status, a MAK after its first data byte gives idle, and a NoMAK there gives standby.
- R11: `wr_start_o` is a one-cycle pulse that coincides with standby entry. It fires on the NoMAK after the command byte of fill-all or clear-all, on the NoMAK after the write-status data byte, and on a NoMAK for write once at least two bytes have followed the command. It fires only if `wr_ok_i` is 1; otherwise the device enters standby without a pulse.
- R12: A missed-edge flag while active gives idle.
- R13: While active, a byte that arrives while an acknowledge is still due, or an acknowledge when none is due, gives idle.
- R14: For read, read-current and read-status, a MAK after any byte keeps the mode active for any number of bytes, and a NoMAK gives standby without a write start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Synchronised level of the serial line |
| byte_vld_i | input | 1 | One-cycle strobe: a byte was received |
| byte_i | input | 8 | Received byte value |
| ack_vld_i | input | 1 | One-cycle strobe: master acknowledge bit received |
| ack_mak_i | input | 1 | 1 = MAK, 0 = NoMAK |
| edge_miss_i | input | 1 | Bit receiver missed an expected edge |
| wip_i | input | 1 | Internal write cycle in progress |
| wr_ok_i | input | 1 | Protection logic permits the pending write |
| mode_o | output | 2 | Current mode (encoding in R1) |
| cmd_valid_o | output | 1 | An accepted command is in progress |
| wr_start_o | output | 1 | One-cycle internal write start |

## Verification
Two functions can land in the same cycle. The first is completion of a standby pulse, which needs the line high on exactly `STBY_CYC` edges. The second is a fault such as a missed edge or a misplaced byte, which on its own sends the device to idle. The bench holds the line high through an active command and raises the fault strobe on exactly the last qualifying edge. It then expects standby, not idle. In the same way, the bench checks that a write start and the return to standby fall on one edge, by sampling both outputs in the cycle after the closing NoMAK and again one cycle later.

// File: rtl/smc_pkg.sv
package smc_pkg;

    typedef enum logic [1:0] {
        M_SHUT = 2'd0,
        M_IDLE = 2'd1,
        M_STBY = 2'd2,
        M_ACT  = 2'd3
    } smc_mode_e;

    typedef enum logic [1:0] {
        PH_ADDR = 2'd0,
        PH_CMD  = 2'd1,
        PH_DATA = 2'd2
    } smc_phase_e;

    typedef enum logic [3:0] {
        CL_NONE  = 4'd0,
        CL_RD    = 4'd1,
        CL_RDCUR = 4'd2,
        CL_WR    = 4'd3,
        CL_WEN   = 4'd4,
        CL_WDIS  = 4'd5,
        CL_RSTAT = 4'd6,
        CL_WSTAT = 4'd7,
        CL_CLR   = 4'd8,
        CL_FILL  = 4'd9
    } smc_cls_e;

    localparam logic [7:0] OP_RD    = 8'h03;
    localparam logic [7:0] OP_RDCUR = 8'h06;
    localparam logic [7:0] OP_WR    = 8'h6C;
    localparam logic [7:0] OP_WEN   = 8'h96;
    localparam logic [7:0] OP_WDIS  = 8'h91;
    localparam logic [7:0] OP_RSTAT = 8'h05;
    localparam logic [7:0] OP_WSTAT = 8'h6E;
    localparam logic [7:0] OP_CLR   = 8'h6D;
    localparam logic [7:0] OP_FILL  = 8'h67;

    typedef struct packed {
        smc_mode_e  mode;
        smc_phase_e phase;
        smc_cls_e   cls;
        logic [1:0] dcnt;
        logic       pend;
        logic       cmd_ok;
        logic       wr_go;
    } smc_state_t;

endpackage

// File: rtl/smc_line_mon.sv
module smc_line_mon #(
    parameter int STBY_CYC = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic rise_o,
    output logic fall_o,
    output logic stby_o
);
    localparam int CW = $clog2(STBY_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(STBY_CYC - 1);
    localparam logic [CW-1:0] TOP  = CW'(STBY_CYC);

    logic          line_q, line_d;
    logic [CW-1:0] hi_q, hi_d;

    always_comb begin
        line_d = line_i;
        if (!line_i)
            hi_d = '0;
        else if (hi_q != TOP)
            hi_d = hi_q + 1'b1;
        else
            hi_d = hi_q;
    end

    assign rise_o = line_i & ~line_q;
    assign fall_o = ~line_i & line_q;
    assign stby_o = line_i && (hi_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= 1'b0;
            hi_q   <= '0;
        end else begin
            line_q <= line_d;
            hi_q   <= hi_d;
        end
    end

    // R3: a standby pulse needs the line high on the previous sample too
    p_pulse_needs_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_o && STBY_CYC > 1) |-> line_q);
endmodule

// File: rtl/smc_cmd_judge.sv
module smc_cmd_judge
    import smc_pkg::*;
(
    input  logic [7:0] code_i,
    input  logic       wip_i,
    output smc_cls_e   cls_o,
    output logic       accept_o
);
    logic busy_block;

    always_comb begin
        unique case (code_i)
            OP_RD:    cls_o = CL_RD;
            OP_RDCUR: cls_o = CL_RDCUR;
            OP_WR:    cls_o = CL_WR;
            OP_WEN:   cls_o = CL_WEN;
            OP_WDIS:  cls_o = CL_WDIS;
            OP_RSTAT: cls_o = CL_RSTAT;
            OP_WSTAT: cls_o = CL_WSTAT;
            OP_CLR:   cls_o = CL_CLR;
            OP_FILL:  cls_o = CL_FILL;
            default:  cls_o = CL_NONE;
        endcase
        busy_block = wip_i && !(cls_o inside {CL_WEN, CL_WDIS, CL_RSTAT});
        accept_o   = (cls_o != CL_NONE) && !busy_block;
    end
endmodule

// File: rtl/smc_mode_ctrl.sv
module smc_mode_ctrl
    import smc_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR = 8'hA0,
    parameter int         STBY_CYC = 600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_i,
    input  logic       byte_vld_i,
    input  logic [7:0] byte_i,
    input  logic       ack_vld_i,
    input  logic       ack_mak_i,
    input  logic       edge_miss_i,
    input  logic       wip_i,
    input  logic       wr_ok_i,
    output logic [1:0] mode_o,
    output logic       cmd_valid_o,
    output logic       wr_start_o
);
    smc_state_t st_q, st_d;
    logic       rise, fall, stby;
    smc_cls_e   jcls;
    logic       jok;

    smc_line_mon #(.STBY_CYC(STBY_CYC)) line_mon_i (
        .clk(clk), .rst_n(rst_n), .line_i(line_i),
        .rise_o(rise), .fall_o(fall), .stby_o(stby)
    );

    smc_cmd_judge judge_i (
        .code_i(byte_i), .wip_i(wip_i), .cls_o(jcls), .accept_o(jok)
    );

    always_comb begin
        st_d       = st_q;
        st_d.wr_go = 1'b0;
        if (stby && st_q.mode != M_SHUT) begin
            st_d.mode   = M_STBY;
            st_d.cmd_ok = 1'b0;
            st_d.pend   = 1'b0;
        end else begin
            unique case (st_q.mode)
                M_SHUT: if (rise) st_d.mode = M_IDLE;
                M_IDLE: ;
                M_STBY: if (fall) begin
                    st_d.mode   = M_ACT;
                    st_d.phase  = PH_ADDR;
                    st_d.cls    = CL_NONE;
                    st_d.dcnt   = '0;
                    st_d.pend   = 1'b0;
                    st_d.cmd_ok = 1'b0;
                end
                M_ACT: begin
                    if (edge_miss_i
                        || (byte_vld_i && st_q.pend)
                        || (ack_vld_i && !st_q.pend)) begin
                        st_d.mode = M_IDLE;
                    end else if (byte_vld_i) begin
                        st_d.pend = 1'b1;
                        unique case (st_q.phase)
                            PH_ADDR: if (byte_i != DEV_ADDR) st_d.mode = M_IDLE;
                            PH_CMD: begin
                                if (jok) begin
                                    st_d.cls    = jcls;
                                    st_d.cmd_ok = 1'b1;
                                end else begin
                                    st_d.mode = M_IDLE;
                                end
                            end
                            default: if (st_q.dcnt != 2'd3) st_d.dcnt = st_q.dcnt + 1'b1;
                        endcase
                    end else if (ack_vld_i) begin
                        st_d.pend = 1'b0;
                        if (!ack_mak_i) st_d.mode = M_STBY;
                        unique case (st_q.phase)
                            PH_ADDR: if (ack_mak_i) st_d.phase = PH_CMD;
                            PH_CMD: begin
                                if (st_q.cls inside {CL_WEN, CL_WDIS, CL_FILL, CL_CLR}) begin
                                    if (ack_mak_i) st_d.mode = M_IDLE;
                                    else st_d.wr_go = wr_ok_i && (st_q.cls inside {CL_FILL, CL_CLR});
                                end else if (ack_mak_i) begin
                                    st_d.phase = PH_DATA;
                                end
                            end
                            default: begin
                                if (st_q.cls == CL_WSTAT) begin
                                    if (ack_mak_i) st_d.mode = M_IDLE;
                                    else st_d.wr_go = wr_ok_i;
                                end else if (st_q.cls == CL_WR && !ack_mak_i) begin
                                    st_d.wr_go = wr_ok_i && (st_q.dcnt >= 2'd2);
                                end
                            end
                        endcase
                    end
                end
                default: st_d.mode = M_SHUT;
            endcase
        end
        if (st_d.mode != M_ACT) st_d.cmd_ok = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: M_SHUT, phase: PH_ADDR, cls: CL_NONE,
                      dcnt: 2'd0, pend: 1'b0, cmd_ok: 1'b0, wr_go: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o      = st_q.mode;
    assign cmd_valid_o = st_q.cmd_ok;
    assign wr_start_o  = st_q.wr_go;

    // R11: write start only together with standby, and one cycle long
    p_wr_in_stby_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start_o |-> (mode_o == M_STBY));
    p_wr_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start_o |=> !wr_start_o);
    // R2: shutdown is left only towards idle
    p_shut_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_o) == M_SHUT && mode_o != M_SHUT) |-> (mode_o == M_IDLE));
    // R4: idle is left only towards standby
    p_idle_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_o) == M_IDLE && mode_o != M_IDLE) |-> (mode_o == M_STBY));
    // R5: active is entered only from standby
    p_act_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_o) != M_ACT && mode_o == M_ACT) |-> ($past(mode_o) == M_STBY));
    // R7: a valid command flag exists only while active
    p_cmd_in_act_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (mode_o == M_ACT));
endmodule

// File: tb/smc_mode_ctrl_tb_top.sv
module smc_mode_ctrl_tb_top;
    localparam logic [7:0] ADDR = 8'hA0;
    localparam int         NSB  = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_i = 1'b0, byte_vld_i = 1'b0, ack_vld_i = 1'b0, ack_mak_i = 1'b0;
    logic       edge_miss_i = 1'b0, wip_i = 1'b0, wr_ok_i = 1'b0;
    logic [7:0] byte_i = 8'h00;
    logic [1:0] mode_o;
    logic       cmd_valid_o, wr_start_o;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    smc_mode_ctrl #(.DEV_ADDR(ADDR), .STBY_CYC(NSB)) dut_i (
        .clk(clk), .rst_n(rst_n), .line_i(line_i),
        .byte_vld_i(byte_vld_i), .byte_i(byte_i),
        .ack_vld_i(ack_vld_i), .ack_mak_i(ack_mak_i),
        .edge_miss_i(edge_miss_i), .wip_i(wip_i), .wr_ok_i(wr_ok_i),
        .mode_o(mode_o), .cmd_valid_o(cmd_valid_o), .wr_start_o(wr_start_o)
    );

    localparam logic [1:0] SHUT = 2'd0, IDLE = 2'd1, STBY = 2'd2, ACT = 2'd3;

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic bit known(input logic [7:0] c);
        return c inside {8'h03, 8'h06, 8'h6C, 8'h96, 8'h91, 8'h05, 8'h6E, 8'h6D, 8'h67};
    endfunction
    function automatic bit busy_ok(input logic [7:0] c);
        return c inside {8'h96, 8'h91, 8'h05};
    endfunction

    task automatic send_byte(input logic [7:0] b);
        byte_i = b; byte_vld_i = 1'b1;
        @(negedge clk); byte_vld_i = 1'b0;
    endtask
    task automatic send_ack(input logic m);
        ack_mak_i = m; ack_vld_i = 1'b1;
        @(negedge clk); ack_vld_i = 1'b0;
    endtask
    task automatic go_standby();
        line_i = 1'b0; @(negedge clk);
        line_i = 1'b1;
        repeat (NSB) @(negedge clk);
    endtask
    task automatic go_active();
        go_standby();
        line_i = 1'b0; @(negedge clk);
    endtask
    task automatic open_cmd(input logic [7:0] c);
        go_active();
        send_byte(ADDR); send_ack(1'b1); send_byte(c);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 mode in reset", mode_o, SHUT);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mode after reset", mode_o, SHUT);
        chk("R1 cmd_valid after reset", cmd_valid_o, 0);
        chk("R1 wr_start after reset", wr_start_o, 0);
        // R2: bytes and faults do nothing in shutdown, a rise gives idle
        send_byte(ADDR); edge_miss_i = 1'b1; @(negedge clk); edge_miss_i = 1'b0;
        chk("R2 shutdown holds", mode_o, SHUT);
        line_i = 1'b1; @(negedge clk);
        chk("R2 rise to idle", mode_o, IDLE);
        repeat (NSB - 1) @(negedge clk);
        chk("R3 pulse from idle", mode_o, STBY);
        // R3 short high period
        line_i = 1'b0; @(negedge clk);
        line_i = 1'b1; @(negedge clk); line_i = 1'b0; @(negedge clk);
        chk("R5 fall to active", mode_o, ACT);
        chk("R5 no cmd yet", cmd_valid_o, 0);
        line_i = 1'b1; repeat (NSB - 1) @(negedge clk);
        line_i = 1'b0; @(negedge clk);
        chk("R3 short high ignored", mode_o, ACT);
        // R6 address sweep with MAK
        for (int a = 0; a < 256; a++) begin
            go_active();
            send_byte(8'(a));
            chk("R6 address judged", mode_o, (a == ADDR) ? ACT : IDLE);
            if (a == ADDR) begin
                send_ack(1'b1);
                chk("R6 MAK to command", mode_o, ACT);
            end
        end
        go_active(); send_byte(ADDR); send_ack(1'b0);
        chk("R6 NoMAK after address", mode_o, STBY);
        // R7 R8 command sweep, idle and busy
        for (int w = 0; w < 2; w++) begin
            for (int c = 0; c < 256; c++) begin
                bit ok;
                wip_i = w[0];
                open_cmd(8'(c));
                ok = known(8'(c)) && (w == 0 || busy_ok(8'(c)));
                chk(w ? "R8 command under busy" : "R7 command judged", mode_o, ok ? ACT : IDLE);
                chk("R7 cmd_valid", cmd_valid_o, ok ? 1 : 0);
            end
        end
        wip_i = 1'b0;
        // R4 idle ignores traffic
        go_active(); send_byte(8'h11);
        line_i = 1'b1; @(negedge clk); line_i = 1'b0; @(negedge clk);
        send_byte(ADDR); send_ack(1'b1); send_byte(8'h03); send_ack(1'b0);
        chk("R4 idle holds", mode_o, IDLE);
        chk("R4 no cmd in idle", cmd_valid_o, 0);
        // R9 single-byte commands
        for (int k = 0; k < 4; k++) begin
            logic [7:0] op;
            op = (k == 0) ? 8'h96 : (k == 1) ? 8'h91 : (k == 2) ? 8'h67 : 8'h6D;
            open_cmd(op); send_ack(1'b1);
            chk("R9 MAK after short command", mode_o, IDLE);
            wr_ok_i = 1'b1;
            open_cmd(op); send_ack(1'b0);
            chk("R9 NoMAK after short command", mode_o, STBY);
            chk("R11 fill/clear start", wr_start_o, (k >= 2) ? 1 : 0);
            @(negedge clk);
            chk("R11 pulse one cycle", wr_start_o, 0);
            wr_ok_i = 1'b0;
        end
        open_cmd(8'h67); send_ack(1'b0);
        chk("R11 no start without permission", wr_start_o, 0);
        chk("R11 standby without permission", mode_o, STBY);
        // R10 status write
        open_cmd(8'h6E); send_ack(1'b1); send_byte(8'h0C); send_ack(1'b1);
        chk("R10 MAK after status data", mode_o, IDLE);
        wr_ok_i = 1'b1;
        open_cmd(8'h6E); send_ack(1'b1); send_byte(8'h0C); send_ack(1'b0);
        chk("R10 NoMAK after status data", mode_o, STBY);
        chk("R11 status write start", wr_start_o, 1);
        // R11 write needs two bytes after the command
        open_cmd(8'h6C); send_ack(1'b1); send_byte(8'h20); send_ack(1'b0);
        chk("R11 write address only", wr_start_o, 0);
        chk("R11 write address only mode", mode_o, STBY);
        for (int n = 2; n < 6; n++) begin
            open_cmd(8'h6C);
            for (int b = 0; b < n; b++) begin
                send_ack(1'b1); send_byte(8'(b * 7));
            end
            send_ack(1'b0);
            chk("R11 write start", wr_start_o, 1);
            chk("R11 write standby", mode_o, STBY);
        end
        wr_ok_i = 1'b0;
        // R14 reads continue
        open_cmd(8'h03);
        for (int b = 0; b < 10; b++) begin
            send_ack(1'b1); send_byte(8'hFF);
        end
        chk("R14 long read active", mode_o, ACT);
        wr_ok_i = 1'b1; send_ack(1'b0);
        chk("R14 read NoMAK", mode_o, STBY);
        chk("R14 read no start", wr_start_o, 0);
        wr_ok_i = 1'b0;
        // R12 R13
        open_cmd(8'h05); edge_miss_i = 1'b1; @(negedge clk); edge_miss_i = 1'b0;
        chk("R12 missed edge", mode_o, IDLE);
        go_active(); send_byte(ADDR); send_byte(8'h03);
        chk("R13 byte while ack due", mode_o, IDLE);
        go_active(); send_ack(1'b1);
        chk("R13 ack with none due", mode_o, IDLE);
        // R3 collision: pulse completes with missed edge in same cycle
        open_cmd(8'h03);
        line_i = 1'b1; repeat (NSB - 1) @(negedge clk);
        edge_miss_i = 1'b1; @(negedge clk); edge_miss_i = 1'b0;
        chk("R3 pulse beats missed edge", mode_o, STBY);
        chk("R3 pulse clears cmd", cmd_valid_o, 0);
        // R3 pulse from standby keeps standby
        go_standby();
        chk("R3 pulse in standby", mode_o, STBY);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule